// File: doc/BRIEF.md
# Carry-Tagged Add Unit

This block is an integer adder that keeps one carry bit beside every architectural register. A plain add writes its sum to the destination register and writes its carry-out into that register's own carry bit. An add-with-carry reads the carry bit that belongs to its first source register, adds it to the two operand words, and writes the new sum and carry back to the destination. Multi-word arithmetic can therefore chain through ordinary registers. There is no single shared flag, so no flag hazard between unrelated instructions, and the register file never needs a third read port.

The unit accepts one operation per cycle and has two stages. In the execute stage it reads the operands, and through a forwarding path it also sees the operation now in write-back. The write-back stage holds the result for one cycle and commits it to the data file and the carry bank at the following edge. A load operation stands for every other instruction that writes a register: it writes a supplied word and clears the destination's carry bit. The committed carry bits are visible as a vector.

Top module: `carry_tag_alu`

## Requirements
- R1: Operation code 2'b01 (add) writes rs1+rs2 (modulo 2^32) to rd and writes the carry-out of that 32-bit addition to rd's carry bit.
- R2: Operation code 2'b10 (add-with-carry) writes rs1+rs2+c to rd, where c is rs1's carry bit, and writes the carry-out of that sum to rd's carry bit.
- R3: The add-with-carry carry-in comes only from rs1's carry bit. The carry bit of rs2 has no effect on it.
- R4: Register 0 reads as data 0 with carry 0. Writes to it are discarded, and bit 0 of `flags_o` is always 0.
- R5: Operation code 2'b11 (load) writes `load_data_i` to rd and clears rd's carry bit.
- R6: If an operation reads the register that the previous operation writes, it receives the new data word and the new carry bit.
- R7: While reset is active and after it is released, all carry bits are 0, all data registers are 0 and `valid_o` is 0.
- R8: `result_o` and `carry_o` show the value written by an operation one cycle after it is issued, with `valid_o` high. `flags_o` takes the new carry bit one cycle later.
- R9: Operation code 2'b00 (idle) writes nothing. `valid_o` is low in the following cycle and `flags_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation: 00 idle, 01 add, 10 add-with-carry, 11 load |
| rd_i | input | 5 | Destination register index |
| rs1_i | input | 5 | First source index, also selects the carry-in |
| rs2_i | input | 5 | Second source index |
| load_data_i | input | 32 | Word written by a load operation |
| result_o | output | 32 | Data word in write-back |
| carry_o | output | 1 | Carry bit in write-back |
| valid_o | output | 1 | Write-back stage holds an operation |
| flags_o | output | 32 | Committed carry bit of each register |

## Verification
The bench builds the unit with its default parameters: 32-bit words and 32 registers. With these values, all-ones operands can overflow the real carry position, and full-width register indices reach every carry bit in `flags_o`. Register indices are drawn from a small range so that back-to-back operations often share a register. This exercises forwarding of both the word and the carry, and chained add-with-carry sequences, on most cycles.

// File: rtl/carry_tag_alu_pkg.sv
package carry_tag_alu_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ADD  = 2'b01,
    OP_ADC  = 2'b10,
    OP_LOAD = 2'b11
  } alu_op_e;
endpackage

// File: rtl/ctag_word_file.sv
module ctag_word_file #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  function automatic logic [XLEN-1:0] fetch(input logic [AW-1:0] a,
                                            input logic w,
                                            input logic [AW-1:0] wadr,
                                            input logic [XLEN-1:0] wdat,
                                            input logic [XLEN-1:0] stored);
    if (a == '0)            return '0;
    else if (w && wadr == a) return wdat;
    else                    return stored;
  endfunction

  assign rd1 = fetch(ra1, we, wa, wd, mem[ra1]);
  assign rd2 = fetch(ra2, we, wa, wd, mem[ra2]);
endmodule

// File: rtl/ctag_flag_bank.sv
module ctag_flag_bank #(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic            wc,
  input  logic [AW-1:0]   ra,
  output logic            rc,
  output logic [NREG-1:0] flags
);
  logic [NREG-1:0] bits;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    if (g == 0) begin : g_zero
      assign bits[g] = 1'b0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                         bits[g] <= 1'b0;
        else if (we && wa == AW'(g))        bits[g] <= wc;
      end
    end
  end

  assign flags = bits;
  assign rc = (ra == '0) ? 1'b0 : ((we && wa == ra) ? wc : bits[ra]);
endmodule

// File: rtl/ctag_adder.sv
module ctag_adder #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic            cout
);
  function automatic logic [XLEN:0] wide_add(input logic [XLEN-1:0] x,
                                             input logic [XLEN-1:0] y,
                                             input logic c);
    return {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, c};
  endfunction

  assign {cout, sum} = wide_add(a, b, cin);
endmodule

// File: rtl/carry_tag_alu.sv
module carry_tag_alu #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [XLEN-1:0] load_data_i,
  output logic [XLEN-1:0] result_o,
  output logic            carry_o,
  output logic            valid_o,
  output logic [NREG-1:0] flags_o
);
  import carry_tag_alu_pkg::*;

  alu_op_e         op;
  logic [XLEN-1:0] ex_a, ex_b, ex_sum, ex_data;
  logic            ex_rs1_carry, ex_cin, ex_cout, ex_carry, ex_issue;
  logic            wb_valid, wb_carry;
  logic [AW-1:0]   wb_rd;
  logic [XLEN-1:0] wb_data;

  assign op = alu_op_e'(op_i);

  ctag_word_file #(.XLEN(XLEN), .NREG(NREG)) u_words (
    .clk(clk), .rst_n(rst_n),
    .we(wb_valid), .wa(wb_rd), .wd(wb_data),
    .ra1(rs1_i), .ra2(rs2_i), .rd1(ex_a), .rd2(ex_b)
  );

  ctag_flag_bank #(.NREG(NREG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .we(wb_valid), .wa(wb_rd), .wc(wb_carry),
    .ra(rs1_i), .rc(ex_rs1_carry), .flags(flags_o)
  );

  assign ex_cin = (op == OP_ADC) ? ex_rs1_carry : 1'b0;

  ctag_adder #(.XLEN(XLEN)) u_add (
    .a(ex_a), .b(ex_b), .cin(ex_cin), .sum(ex_sum), .cout(ex_cout)
  );

  assign ex_issue = (op != OP_IDLE);
  assign ex_data  = (op == OP_LOAD) ? load_data_i : ex_sum;
  assign ex_carry = (op == OP_LOAD) ? 1'b0 : ex_cout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_rd    <= '0;
      wb_data  <= '0;
      wb_carry <= 1'b0;
    end else begin
      wb_valid <= ex_issue;
      wb_rd    <= rd_i;
      wb_data  <= ex_data;
      wb_carry <= ex_carry;
    end
  end

  assign result_o = wb_data;
  assign carry_o  = wb_carry;
  assign valid_o  = wb_valid;
endmodule

// File: rtl/carry_tag_alu_chk.sv
module carry_tag_alu_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] ex_a,
  input logic [XLEN-1:0] ex_b,
  input logic            ex_cin,
  input logic [XLEN-1:0] result_o,
  input logic            carry_o,
  input logic            valid_o,
  input logic [NREG-1:0] flags_o
);
  // R1
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 2'b01) |->
      ({carry_o, result_o} == ($past({1'b0, ex_a}) + $past({1'b0, ex_b}))));

  // R2
  adc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 2'b10) |->
      ({carry_o, result_o} == ($past({1'b0, ex_a}) + $past({1'b0, ex_b})
                               + {{XLEN{1'b0}}, $past(ex_cin)})));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[0] == 1'b0);

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 2'b11) |-> (carry_o == 1'b0));

  // R7
  reset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags_o == '0 && !valid_o));

  // R8
  valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_o == ($past(op_i) != 2'b00)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid_o)) |-> $stable(flags_o));
endmodule

bind carry_tag_alu carry_tag_alu_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i),
  .ex_a(ex_a), .ex_b(ex_b), .ex_cin(ex_cin),
  .result_o(result_o), .carry_o(carry_o), .valid_o(valid_o), .flags_o(flags_o)
);

// File: tb/carry_tag_alu_test.sv
module carry_tag_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [4:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] result_o;
  logic        carry_o, valid_o;
  logic [31:0] flags_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference state
  logic [31:0] m_reg [32];
  logic        m_flag [32];
  bit          p_v;
  logic [4:0]  p_rd;
  logic [31:0] p_data;
  logic        p_c;

  carry_tag_alu uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rd_i(rd_i), .rs1_i(rs1_i),
    .rs2_i(rs2_i), .load_data_i(load_data_i), .result_o(result_o),
    .carry_o(carry_o), .valid_o(valid_o), .flags_o(flags_o)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [31:0] rd_word(input logic [4:0] i);
    if (i == 0) return 32'd0;
    if (p_v && p_rd == i) return p_data;
    return m_reg[i];
  endfunction

  function automatic logic rd_flag(input logic [4:0] i);
    if (i == 0) return 1'b0;
    if (p_v && p_rd == i) return p_c;
    return m_flag[i];
  endfunction

  function automatic logic [31:0] flag_vec();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_flag[i];
    return v;
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(input logic [1:0] op, input logic [4:0] rd,
                      input logic [4:0] rs1, input logic [4:0] rs2,
                      input logic [31:0] ld, input string tag);
    logic [32:0] wide;
    logic [31:0] e_data;
    logic        e_c;
    op_i = op; rd_i = rd; rs1_i = rs1; rs2_i = rs2; load_data_i = ld;
    case (op)
      2'b01: wide = {1'b0, rd_word(rs1)} + {1'b0, rd_word(rs2)};
      2'b10: wide = {1'b0, rd_word(rs1)} + {1'b0, rd_word(rs2)} + 33'(rd_flag(rs1));
      default: wide = {1'b0, ld};
    endcase
    e_data = wide[31:0];
    e_c    = (op == 2'b11) ? 1'b0 : wide[32];
    @(posedge clk);
    if (p_v && p_rd != 0) begin
      m_reg[p_rd]  = p_data;
      m_flag[p_rd] = p_c;
    end
    p_v = (op != 2'b00); p_rd = rd; p_data = e_data; p_c = e_c;
    @(negedge clk);
    cmp(tag, "valid", 32'(valid_o), 32'(p_v));
    if (p_v) begin
      cmp(tag, "result", result_o, p_data);
      cmp(tag, "carry", 32'(carry_o), 32'(p_c));
    end
    cmp(tag, "flags", flags_o, flag_vec());
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'b01: return "R1";
      2'b10: return "R2";
      2'b11: return "R5";
      default: return "R9";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin m_reg[i] = '0; m_flag[i] = 1'b0; end
    p_v = 0; p_rd = '0; p_data = '0; p_c = 1'b0;
    repeat (3) @(negedge clk);
    // R7: state under reset
    cmp("R7", "flags_in_reset", flags_o, 32'd0);
    cmp("R7", "valid_in_reset", 32'(valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R7", "flags_after_reset", flags_o, 32'd0);
    cmp("R7", "valid_after_reset", 32'(valid_o), 32'd0);

    step(2'b11, 5'd1, 5'd0, 5'd0, 32'hFFFF_FFFF, "R5");
    step(2'b11, 5'd2, 5'd0, 5'd0, 32'h0000_0001, "R5");
    step(2'b01, 5'd3, 5'd1, 5'd2, 32'h0, "R1");       // 0, carry 1
    step(2'b10, 5'd4, 5'd3, 5'd2, 32'h0, "R6");       // fwd x3 flag: 0+1+1=2
    step(2'b10, 5'd5, 5'd2, 5'd3, 32'h0, "R3");       // rs2 carry ignored: 1
    step(2'b00, 5'd0, 5'd0, 5'd0, 32'h0, "R8");
    cmp("R8", "flag3_committed", 32'(flags_o[3]), 32'd1);
    step(2'b01, 5'd0, 5'd1, 5'd2, 32'h0, "R4");       // write to x0 dropped
    step(2'b10, 5'd6, 5'd0, 5'd1, 32'h0, "R4");       // x0 carry in is 0
    step(2'b00, 5'd0, 5'd0, 5'd0, 32'h0, "R4");
    cmp("R4", "flag0", 32'(flags_o[0]), 32'd0);
    step(2'b01, 5'd7, 5'd0, 5'd0, 32'h0, "R4");       // x0 data reads 0
    step(2'b11, 5'd3, 5'd0, 5'd0, 32'h0000_0005, "R5"); // clears flag3
    step(2'b00, 5'd0, 5'd0, 5'd0, 32'h0, "R9");
    step(2'b00, 5'd0, 5'd0, 5'd0, 32'h0, "R9");
    cmp("R5", "flag3_cleared", 32'(flags_o[3]), 32'd0);
    // chained multiword add: two 64-bit values with a carry across words
    step(2'b11, 5'd10, 5'd0, 5'd0, 32'h8000_0000, "R5");
    step(2'b11, 5'd11, 5'd0, 5'd0, 32'h8000_0001, "R5");
    step(2'b01, 5'd12, 5'd10, 5'd11, 32'h0, "R1");
    step(2'b10, 5'd13, 5'd12, 5'd1, 32'h0, "R6");
    step(2'b10, 5'd13, 5'd13, 5'd13, 32'h0, "R6");
    step(2'b10, 5'd31, 5'd13, 5'd1, 32'h0, "R2");

    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      step(op, 5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)),
           5'($urandom_range(0, 5)),
           ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom(),
           tag_of(op));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule